// File: doc/BRIEF.md
# Packed Lane Conditional Move Unit

This block decodes and executes a small group of packed conditional-move instructions. It works on a file of sixteen 32-bit vector registers. A 32-bit instruction word names three registers: a condition register, a source register and a destination register. For each lane, the unit either copies the source lane into the destination or leaves the old destination lane in place.

The lane can be one 32-bit word, two 16-bit halfwords or four bytes. Each lane is tested on its own against zero. A single 3-bit sub-opcode selects both the lane width and the polarity of the test, which is either move-if-zero or move-if-nonzero. Sub-opcodes that name no operation raise a reserved-instruction flag and leave the registers untouched.

The rest of the pipeline loads operand values through a plain write port. A combinational debug read port lets any register be inspected.

Top module: `cmov_unit`

## Requirements
- R1: During and after synchronous reset every register reads zero on `dbg_data`, and `illegal_op` is low.
- R2: An issued word executes only when its bits [5:0] equal 0x39. Any other major opcode writes no register and leaves `illegal_op` low.
- R3: Register indices come from fixed fields: bits [9:6] give the destination, bits [13:10] the condition and bits [17:14] the source. Bits [20:18] give the sub-opcode.
- R4: Sub-opcode 0 (byte, move-if-zero): each of the four bytes of the destination takes the matching source byte only when the matching condition byte is zero.
- R5: Sub-opcode 1 (byte, move-if-nonzero): a destination byte takes the source byte only when the matching condition byte is non-zero.
- R6: Sub-opcodes 2 (if-zero) and 3 (if-nonzero) test the upper halfword [31:16] and the lower halfword [15:0] of the condition independently. Each halfword of the destination is replaced or kept on its own.
- R7: Sub-opcodes 4 (if-zero) and 5 (if-nonzero) test the whole 32-bit condition word. The destination becomes the source when the test holds, and is unchanged otherwise.
- R8: Sub-opcodes 6 and 7 write no register. They make `illegal_op` high for exactly the one cycle after the clock edge that took the instruction.
- R9: Register 0 always reads zero. Writes to it from a move or from the load port are dropped.
- R10: When the destination is also the condition or source register, the result is computed from the values held before the write.
- R11: A move takes effect at the clock edge where `issue_valid` is sampled high. The new value is readable on `dbg_data` from that edge on.
- R12: The load port writes `ld_data` to register `ld_idx` at the clock edge. If a move writes the same register in the same cycle, the move result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| ld_en | input | 1 | Register load enable |
| ld_idx | input | 4 | Register load index |
| ld_data | input | 32 | Register load value |
| dbg_idx | input | 4 | Debug read index |
| dbg_data | output | 32 | Debug read value (combinational) |
| illegal_op | output | 1 | Reserved sub-opcode seen, registered |

## Verification
Register results become visible at the first clock edge after the strobe, since the move is written at that edge. The bench drives each strobe on a falling edge, lets one rising edge pass, and reads `dbg_data` at the next falling edge. `illegal_op` is a register loaded at that same rising edge. It is therefore sampled at that falling edge, and once more a cycle later to confirm that it drops. Every expected value comes from a lane-by-lane model in the bench.

// File: rtl/cmov_pkg.sv
package cmov_pkg;

    localparam int XLEN      = 32;
    localparam int NREG      = 16;
    localparam int IDXW      = $clog2(NREG);
    localparam int NBYTE     = XLEN / 8;
    localparam int NHALF     = XLEN / 16;
    localparam logic [5:0] MAJOR_CMOV = 6'h39;

    typedef enum logic [1:0] {
        LM_B8  = 2'd0,
        LM_H16 = 2'd1,
        LM_W32 = 2'd2
    } lane_mode_t;

    typedef struct packed {
        logic             exec;
        logic             rsvd;
        lane_mode_t       mode;
        logic             on_zero;
        logic [IDXW-1:0]  rd;
        logic [IDXW-1:0]  rc;
        logic [IDXW-1:0]  rs;
    } dec_t;

    function automatic lane_mode_t sub_to_mode(input logic [2:0] sub);
        case (sub[2:1])
            2'd0:    return LM_B8;
            2'd1:    return LM_H16;
            default: return LM_W32;
        endcase
    endfunction

endpackage

// File: rtl/cmov_decode.sv
module cmov_decode
    import cmov_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] word,
    output dec_t        dec
);
    logic       group_hit;
    logic [2:0] sub;

    always_comb begin
        group_hit   = valid && (word[5:0] == MAJOR_CMOV);
        sub         = word[20:18];
        dec.rd      = word[9:6];
        dec.rc      = word[13:10];
        dec.rs      = word[17:14];
        dec.mode    = sub_to_mode(sub);
        dec.on_zero = ~sub[0];
        dec.rsvd    = group_hit && (sub[2:1] == 2'b11);
        dec.exec    = group_hit && (sub[2:1] != 2'b11);
    end
endmodule

// File: rtl/cmov_lane_merge.sv
module cmov_lane_merge
    import cmov_pkg::*;
#(
    parameter int W = XLEN
) (
    input  lane_mode_t     mode,
    input  logic           on_zero,
    input  logic [W-1:0]   cond,
    input  logic [W-1:0]   src,
    input  logic [W-1:0]   dst,
    output logic [W-1:0]   result
);
    localparam int NB = W / 8;
    localparam int NH = W / 16;

    logic [NB-1:0] byte_zero;
    logic [NH-1:0] half_zero;
    logic          word_zero;

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_bz
            assign byte_zero[b] = (cond[8*b +: 8] == 8'h00);
        end
        for (b = 0; b < NH; b++) begin : g_hz
            assign half_zero[b] = byte_zero[2*b] & byte_zero[2*b+1];
        end
    endgenerate

    assign word_zero = &byte_zero;

    generate
        for (b = 0; b < NB; b++) begin : g_lane
            logic lane_zero;
            logic take;
            always_comb begin
                case (mode)
                    LM_B8:   lane_zero = byte_zero[b];
                    LM_H16:  lane_zero = half_zero[b/2];
                    default: lane_zero = word_zero;
                endcase
                take = on_zero ? lane_zero : ~lane_zero;
            end
            assign result[8*b +: 8] = take ? src[8*b +: 8] : dst[8*b +: 8];
        end
    endgenerate
endmodule

// File: rtl/cmov_regfile.sv
module cmov_regfile
    import cmov_pkg::*;
#(
    parameter int N  = NREG,
    parameter int W  = XLEN,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mv_we,
    input  logic [IW-1:0] mv_idx,
    input  logic [W-1:0]  mv_data,
    input  logic          ld_we,
    input  logic [IW-1:0] ld_idx,
    input  logic [W-1:0]  ld_data,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic [IW-1:0] rc_idx,
    output logic [W-1:0]  rc_data,
    input  logic [IW-1:0] rdbg_idx,
    output logic [W-1:0]  rdbg_data
);
    logic [W-1:0] mem [N];

    assign mem[0] = '0;

    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst)
                    mem[g] <= '0;
                else if (mv_we && (mv_idx == IW'(g)))
                    mem[g] <= mv_data;
                else if (ld_we && (ld_idx == IW'(g)))
                    mem[g] <= ld_data;
            end
        end
    endgenerate

    assign ra_data   = mem[ra_idx];
    assign rb_data   = mem[rb_idx];
    assign rc_data   = mem[rc_idx];
    assign rdbg_data = mem[rdbg_idx];
endmodule

// File: rtl/cmov_unit.sv
module cmov_unit
    import cmov_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                issue_valid,
    input  logic [31:0]         instr,
    input  logic                ld_en,
    input  logic [IDXW-1:0]     ld_idx,
    input  logic [XLEN-1:0]     ld_data,
    input  logic [IDXW-1:0]     dbg_idx,
    output logic [XLEN-1:0]     dbg_data,
    output logic                illegal_op
);
    dec_t            dec;
    logic [XLEN-1:0] cond_q;
    logic [XLEN-1:0] src_q;
    logic [XLEN-1:0] dst_q;
    logic [XLEN-1:0] mv_data;
    logic            mv_we;

    cmov_decode u_dec (
        .valid (issue_valid),
        .word  (instr),
        .dec   (dec)
    );

    cmov_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .mv_we     (mv_we),
        .mv_idx    (dec.rd),
        .mv_data   (mv_data),
        .ld_we     (ld_en),
        .ld_idx    (ld_idx),
        .ld_data   (ld_data),
        .ra_idx    (dec.rc),
        .ra_data   (cond_q),
        .rb_idx    (dec.rs),
        .rb_data   (src_q),
        .rc_idx    (dec.rd),
        .rc_data   (dst_q),
        .rdbg_idx  (dbg_idx),
        .rdbg_data (dbg_data)
    );

    cmov_lane_merge #(.W(XLEN)) u_merge (
        .mode    (dec.mode),
        .on_zero (dec.on_zero),
        .cond    (cond_q),
        .src     (src_q),
        .dst     (dst_q),
        .result  (mv_data)
    );

    assign mv_we = dec.exec;

    always_ff @(posedge clk) begin
        if (rst)
            illegal_op <= 1'b0;
        else
            illegal_op <= dec.rsvd;
    end
endmodule

// File: rtl/cmov_unit_chk.sv
module cmov_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        issue_valid,
    input logic [31:0] instr,
    input logic [3:0]  dbg_idx,
    input logic [31:0] dbg_data,
    input logic        illegal_op,
    input logic        mv_we,
    input logic [31:0] cond_q,
    input logic [31:0] src_q,
    input logic [31:0] mv_data
);
    logic is_grp;
    logic is_rsvd;
    assign is_grp  = issue_valid && (instr[5:0] == 6'h39);
    assign is_rsvd = is_grp && (instr[20:19] == 2'b11);

    assert_rsvd_flag_R8: assert property (@(posedge clk) disable iff (rst)
        is_rsvd |=> illegal_op);

    assert_rsvd_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
        is_rsvd |-> !mv_we);

    assert_foreign_op_R2: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && instr[5:0] != 6'h39) |-> !mv_we);

    assert_idle_flag_R1: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> !illegal_op);

    assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst)
        (dbg_idx == 4'd0) |-> (dbg_data == 32'd0));

    assert_word_if_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (mv_we && instr[20:18] == 3'd4 && cond_q == 32'd0) |-> (mv_data == src_q));
endmodule

bind cmov_unit cmov_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .instr       (instr),
    .dbg_idx     (dbg_idx),
    .dbg_data    (dbg_data),
    .illegal_op  (illegal_op),
    .mv_we       (mv_we),
    .cond_q      (cond_q),
    .src_q       (src_q),
    .mv_data     (mv_data)
);

// File: tb/test_cmov_unit.sv
module test_cmov_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [31:0] instr;
    logic        ld_en;
    logic [3:0]  ld_idx;
    logic [31:0] ld_data;
    logic [3:0]  dbg_idx;
    logic [31:0] dbg_data;
    logic        illegal_op;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [31:0] C_MIX  = 32'h00FF_0000;
    localparam logic [31:0] C_HALF = 32'h0000_0100;
    localparam logic [31:0] SRC    = 32'h1122_3344;
    localparam logic [31:0] DST    = 32'hAABB_CCDD;

    always #10 clk = ~clk;

    cmov_unit i_cmov_unit (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data), .illegal_op(illegal_op)
    );

    function automatic logic [31:0] model(input logic [2:0] sub,
        input logic [31:0] c, input logic [31:0] s, input logic [31:0] d);
        logic [31:0] r = d;
        logic        z;
        if (sub == 3'd0 || sub == 3'd1) begin
            for (int i = 0; i < 4; i++) begin
                z = (c[8*i +: 8] == 8'h00);
                if (z == (sub == 3'd0)) r[8*i +: 8] = s[8*i +: 8];
            end
        end else if (sub == 3'd2 || sub == 3'd3) begin
            for (int i = 0; i < 2; i++) begin
                z = (c[16*i +: 16] == 16'h0000);
                if (z == (sub == 3'd2)) r[16*i +: 16] = s[16*i +: 16];
            end
        end else if (sub == 3'd4 || sub == 3'd5) begin
            z = (c == 32'd0);
            if (z == (sub == 3'd4)) r = s;
        end
        return r;
    endfunction

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [2:0] sub,
        input logic [3:0] rd, input logic [3:0] rc, input logic [3:0] rs);
        return {11'd0, sub, rs, rc, rd, op};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] idx, input logic [31:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [3:0] idx, input logic [31:0] exp);
        dbg_idx = idx;
        #1;
        check(req, dbg_data, exp);
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        issue_valid = 1'b1; instr = w;
        @(negedge clk);
        issue_valid = 1'b0; instr = '0;
    endtask

    task automatic setup3(input logic [31:0] c);
        load(4'd1, c);
        load(4'd2, SRC);
        load(4'd3, DST);
    endtask

    task automatic run_case(input string req, input logic [2:0] sub, input logic [31:0] c);
        setup3(c);
        issue(enc(6'h39, sub, 4'd3, 4'd1, 4'd2));
        read_check(req, 4'd3, model(sub, c, SRC, DST));
        read_check(req, 4'd1, c);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 16; i++) read_check("R1", 4'(i), 32'd0);
        check("R1 flag", {31'd0, illegal_op}, 32'd0);
    endtask

    task automatic t_bytes;
        run_case("R4 byte-zero", 3'd0, C_MIX);
        check("R4 value", model(3'd0, C_MIX, SRC, DST), 32'h11BB_3344);
        run_case("R5 byte-nonzero", 3'd1, C_MIX);
        check("R5 value", model(3'd1, C_MIX, SRC, DST), 32'hAA22_CCDD);
        run_case("R4 all-zero cond", 3'd0, 32'd0);
    endtask

    task automatic t_halves;
        run_case("R6 half-zero", 3'd2, C_HALF);
        run_case("R6 half-nonzero", 3'd3, C_HALF);
        check("R6 value", model(3'd2, C_HALF, SRC, DST), 32'h1122_CCDD);
    endtask

    task automatic t_words;
        run_case("R7 word-zero fails", 3'd4, C_HALF);
        run_case("R7 word-nonzero", 3'd5, C_HALF);
        run_case("R7 word-zero holds", 3'd4, 32'd0);
        run_case("R7 word-nonzero fails", 3'd5, 32'd0);
    endtask

    task automatic t_fields;
        load(4'd7, 32'h0000_FFFF);
        load(4'd9, 32'hCAFE_F00D);
        load(4'd12, 32'h5555_AAAA);
        issue(enc(6'h39, 3'd2, 4'd12, 4'd7, 4'd9));
        read_check("R3 fields", 4'd12, 32'hCAFE_AAAA);
        read_check("R3 src kept", 4'd9, 32'hCAFE_F00D);
    endtask

    task automatic t_reserved;
        setup3(32'd0);
        @(negedge clk);
        issue_valid = 1'b1; instr = enc(6'h39, 3'd6, 4'd3, 4'd1, 4'd2);
        @(negedge clk);
        issue_valid = 1'b0; instr = '0;
        check("R8 flag sub6", {31'd0, illegal_op}, 32'd1);
        read_check("R8 no write", 4'd3, DST);
        @(negedge clk);
        check("R8 flag drops", {31'd0, illegal_op}, 32'd0);
        issue(enc(6'h39, 3'd7, 4'd3, 4'd1, 4'd2));
        check("R8 flag sub7", {31'd0, illegal_op}, 32'd1);
        read_check("R8 no write 7", 4'd3, DST);
    endtask

    task automatic t_foreign;
        setup3(32'd0);
        issue(enc(6'h38, 3'd4, 4'd3, 4'd1, 4'd2));
        read_check("R2 foreign op", 4'd3, DST);
        check("R2 no flag", {31'd0, illegal_op}, 32'd0);
        issue(enc(6'h39, 3'd4, 4'd3, 4'd1, 4'd2));
        read_check("R2 group op", 4'd3, SRC);
    endtask

    task automatic t_zero_reg;
        setup3(32'd0);
        issue(enc(6'h39, 3'd4, 4'd0, 4'd1, 4'd2));
        read_check("R9 move to r0", 4'd0, 32'd0);
        load(4'd0, 32'hFFFF_FFFF);
        read_check("R9 load to r0", 4'd0, 32'd0);
        issue(enc(6'h39, 3'd4, 4'd3, 4'd0, 4'd2));
        read_check("R9 r0 cond", 4'd3, SRC);
    endtask

    task automatic t_alias;
        setup3(C_MIX);
        issue(enc(6'h39, 3'd0, 4'd1, 4'd1, 4'd2));
        read_check("R10 rd=rc", 4'd1, model(3'd0, C_MIX, SRC, C_MIX));
        setup3(C_MIX);
        issue(enc(6'h39, 3'd1, 4'd1, 4'd1, 4'd1));
        read_check("R10 all same", 4'd1, C_MIX);
    endtask

    task automatic t_timing;
        setup3(32'd0);
        dbg_idx = 4'd3;
        @(negedge clk);
        issue_valid = 1'b1; instr = enc(6'h39, 3'd4, 4'd3, 4'd1, 4'd2);
        #1;
        check("R11 before edge", dbg_data, DST);
        @(negedge clk);
        issue_valid = 1'b0; instr = '0;
        check("R11 after edge", dbg_data, SRC);
    endtask

    task automatic t_conflict;
        setup3(32'd0);
        @(negedge clk);
        issue_valid = 1'b1; instr = enc(6'h39, 3'd4, 4'd3, 4'd1, 4'd2);
        ld_en = 1'b1; ld_idx = 4'd3; ld_data = 32'h0BAD_0BAD;
        @(negedge clk);
        issue_valid = 1'b0; instr = '0; ld_en = 1'b0;
        read_check("R12 move wins", 4'd3, SRC);
        load(4'd5, 32'h1357_9BDF);
        read_check("R12 load", 4'd5, 32'h1357_9BDF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; issue_valid = 1'b0; instr = '0;
        ld_en = 1'b0; ld_idx = '0; ld_data = '0; dbg_idx = '0;
        load(4'd4, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_bytes;
        t_halves;
        t_words;
        t_fields;
        t_reserved;
        t_foreign;
        t_zero_reg;
        t_alias;
        t_timing;
        t_conflict;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule